// File: doc/BRIEF.md
# Auto-Reload Timer with Carrier Gating

This block is a programmable down counter with an auto-reload register, an underflow flag and a three-bit control register. It counts rising edges of one of two slow count sources, either the carrier waveform or a tap of the watchdog counter. When it runs past zero it reloads, so a reload value of n divides the selected source by n+1.

The block also drives a gate for the carrier output. With auto-control on and the timer running, the gate flips at every underflow. Loading a new reload value before each underflow therefore chops the carrier into bursts and gaps of chosen lengths.

The count sources are asynchronous to the system clock. Each passes through a flop synchronizer and a rising-edge detector, so every state change happens on the system clock. Software polls the underflow flag with a test command. The test reports the flag and clears it when it was set.

Top module: `rtg_burst_timer`

## Requirements
- R1: After reset, count_o is 0, flag_o is 0, gate_o is 1, the reload value is 0 and the control register is 000 (stopped, carrier source, auto-control off).
- R2: While the timer is stopped, a value write (load_en_i) sets both the counter and the reload register; count_o shows the value one clock later.
- R3: While the timer is running, a value write changes only the reload register. count_o is unaffected, and the new value appears at the next underflow.
- R4: While running, each rising edge of the selected source decrements the counter by exactly one, however long the source stays high.
- R5: An edge that arrives while the counter is 0 is an underflow. It loads the reload value and sets flag_o, so a reload value of n gives one underflow per n+1 edges; n = 0 gives an underflow on every edge.
- R6: Control bit 0 = 1 runs the timer. With bit 0 = 0, source edges leave the counter and flag unchanged.
- R7: Control bit 1 selects the count source: 0 = carrier_i, 1 = wdt_tap_i. Edges on the unselected input are ignored.
- R8: While flag_test_i is high, skip_o equals flag_o. A test with the flag set clears it at that clock edge, unless an underflow occurs in the same cycle.
- R9: With control bit 2 = 1 and the timer running, gate_o is 1 at start and inverts at every underflow.
- R10: gate_o is 1 whenever control bit 2 is 0 or the timer is stopped. This takes effect in the cycle the control register takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_i | input | 1 | Carrier waveform, count source 0 (asynchronous) |
| wdt_tap_i | input | 1 | Watchdog counter tap, count source 1 (asynchronous) |
| load_en_i | input | 1 | Value write strobe |
| load_val_i | input | CNT_W | Value to write |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_val_i | input | 3 | Control value: bit2 auto-control, bit1 source select, bit0 run |
| flag_test_i | input | 1 | Test-and-clear command for the underflow flag |
| flag_o | output | 1 | Underflow flag |
| skip_o | output | 1 | Test result (flag set while test is high) |
| count_o | output | CNT_W | Current counter value |
| gate_o | output | 1 | Carrier enable gate |

## Verification
A counter that skips or repeats a value shows on count_o within one source edge. Over a full period it also shifts the underflow by a cycle, which moves the flag and gate flip to the wrong edge. A stale reload register shows only at the next underflow, as a wrong value on count_o right after the flag rises. A wrong gate toggle bit stays hidden while auto-control is off, because the gate is forced high then. It becomes visible at the first underflow after auto-control is turned on, when gate_o fails to fall.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   // control register layout: bit2 auto-control, bit1 source, bit0 run
   typedef struct packed {
      logic auto_en;
      logic src_wdt;
      logic run;
   } rtg_ctl_t;

   localparam int RTG_CTL_W = $bits(rtg_ctl_t);
endpackage

// File: rtl/rtg_edge_sync.sv
module rtg_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic rise_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("rtg_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] stage_q;
   logic                   prev_q;

   for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[gi] <= 1'b0;
            else        stage_q[gi] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[gi] <= 1'b0;
            else        stage_q[gi] <= stage_q[gi-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= stage_q[SYNC_STAGES-1];
   end

   assign rise_o = stage_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             uf_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("rtg_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] reload_nx;
   logic             at_zero;

   assign at_zero   = (cnt_q == '0);
   assign reload_nx = wr_en_i ? wr_val_i : reload_q;
   assign uf_o      = run_i & tick_i & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reload_q <= '0;
      else        reload_q <= reload_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run_i) begin
         if (tick_i) cnt_q <= at_zero ? reload_nx : cnt_q - 1'b1;
      end else if (wr_en_i) begin
         cnt_q <= wr_val_i;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/rtg_gate.sv
module rtg_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic uf_i,
   output logic gate_o
);
   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tog_q <= 1'b1;
      else if (!active_i) tog_q <= 1'b1;
      else if (uf_i)     tog_q <= ~tog_q;
   end

   assign gate_o = active_i ? tog_q : 1'b1;
endmodule

// File: rtl/rtg_burst_timer.sv
module rtg_burst_timer #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     carrier_i,
   input  logic                     wdt_tap_i,
   input  logic                     load_en_i,
   input  logic [CNT_W-1:0]         load_val_i,
   input  logic                     ctl_we_i,
   input  logic [rtg_pkg::RTG_CTL_W-1:0] ctl_val_i,
   input  logic                     flag_test_i,
   output logic                     flag_o,
   output logic                     skip_o,
   output logic [CNT_W-1:0]         count_o,
   output logic                     gate_o
);
   import rtg_pkg::*;

   rtg_ctl_t ctl_q;
   logic     src_sel_w;
   logic     tick_w;
   logic     run_w;
   logic     auto_on_w;
   logic     uf_w;
   logic     flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= '0;
      else if (ctl_we_i) ctl_q <= rtg_ctl_t'(ctl_val_i);
   end

   assign run_w     = ctl_q.run;
   assign auto_on_w = ctl_q.run & ctl_q.auto_en;
   assign src_sel_w = ctl_q.src_wdt ? wdt_tap_i : carrier_i;

   rtg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (src_sel_w),
      .rise_o (tick_w)
   );

   rtg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_w),
      .tick_i   (tick_w),
      .wr_en_i  (load_en_i),
      .wr_val_i (load_val_i),
      .cnt_o    (count_o),
      .uf_o     (uf_w)
   );

   rtg_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (auto_on_w),
      .uf_i     (uf_w),
      .gate_o   (gate_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flag_q <= 1'b0;
      else if (uf_w)                 flag_q <= 1'b1;
      else if (flag_test_i && flag_q) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign skip_o = flag_test_i & flag_q;
endmodule

// File: rtl/rtg_burst_timer_chk.sv
module rtg_burst_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             auto_on,
   input logic             tick,
   input logic             uf,
   input logic             load_en,
   input logic             flag_test,
   input logic             flag,
   input logic [CNT_W-1:0] count,
   input logic             gate
);
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load_en) |=> $stable(count)); // R6

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && count != '0) |=> (count == $past(count) - 1'b1)); // R4

   AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && count == '0) |=> flag); // R5

   AST_TEST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_test && flag && !uf) |=> !flag); // R8

   AST_GATE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(auto_on) |-> gate); // R9

   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_on && $past(auto_on) && !$past(uf)) |-> $stable(gate)); // R9
endmodule

bind rtg_burst_timer rtg_burst_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run_w),
   .auto_on   (auto_on_w),
   .tick      (tick_w),
   .uf        (uf_w),
   .load_en   (load_en_i),
   .flag_test (flag_test_i),
   .flag      (flag_o),
   .count     (count_o),
   .gate      (gate_o)
);

// File: tb/rtg_burst_timer_tb.sv
module rtg_burst_timer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;

   // vector: op[24:22] data[21:14] cnt[13:6] flag[5] gate[4] req[3:0]
   // op 0 value write, 1 control write, 2 carrier pulse, 3 tap pulse, 4 test
   localparam int NV = 34;
   localparam logic [24:0] VEC [NV] = '{
      {3'd0, 8'd3, 8'd3, 1'b0, 1'b1, 4'd2},   // R2 write while stopped
      {3'd2, 8'd0, 8'd3, 1'b0, 1'b1, 4'd6},   // R6 stopped ignores edges
      {3'd1, 8'd1, 8'd3, 1'b0, 1'b1, 4'd10},  // R10 run, auto off
      {3'd2, 8'd0, 8'd2, 1'b0, 1'b1, 4'd4},   // R4
      {3'd3, 8'd0, 8'd2, 1'b0, 1'b1, 4'd7},   // R7 tap ignored
      {3'd2, 8'd0, 8'd1, 1'b0, 1'b1, 4'd4},
      {3'd2, 8'd0, 8'd0, 1'b0, 1'b1, 4'd4},
      {3'd2, 8'd0, 8'd3, 1'b1, 1'b1, 4'd5},   // R5 underflow reload
      {3'd4, 8'd1, 8'd3, 1'b0, 1'b1, 4'd8},   // R8 skip and clear
      {3'd4, 8'd0, 8'd3, 1'b0, 1'b1, 4'd8},   // R8 no skip
      {3'd0, 8'd1, 8'd3, 1'b0, 1'b1, 4'd3},   // R3 reload only
      {3'd2, 8'd0, 8'd2, 1'b0, 1'b1, 4'd3},
      {3'd2, 8'd0, 8'd1, 1'b0, 1'b1, 4'd3},
      {3'd2, 8'd0, 8'd0, 1'b0, 1'b1, 4'd3},
      {3'd2, 8'd0, 8'd1, 1'b1, 1'b1, 4'd3},   // R3 new value at underflow
      {3'd4, 8'd1, 8'd1, 1'b0, 1'b1, 4'd8},
      {3'd1, 8'd5, 8'd1, 1'b0, 1'b1, 4'd9},   // R9 gate starts high
      {3'd2, 8'd0, 8'd0, 1'b0, 1'b1, 4'd9},
      {3'd2, 8'd0, 8'd1, 1'b1, 1'b0, 4'd9},   // R9 toggle
      {3'd2, 8'd0, 8'd0, 1'b1, 1'b0, 4'd9},
      {3'd2, 8'd0, 8'd1, 1'b1, 1'b1, 4'd9},   // R9 toggle back
      {3'd1, 8'd1, 8'd1, 1'b1, 1'b1, 4'd10},  // R10 auto off
      {3'd1, 8'd0, 8'd1, 1'b1, 1'b1, 4'd10},
      {3'd4, 8'd1, 8'd1, 1'b0, 1'b1, 4'd8},
      {3'd0, 8'd0, 8'd0, 1'b0, 1'b1, 4'd2},
      {3'd1, 8'd3, 8'd0, 1'b0, 1'b1, 4'd7},   // R7 select tap
      {3'd2, 8'd0, 8'd0, 1'b0, 1'b1, 4'd7},   // R7 carrier ignored
      {3'd3, 8'd0, 8'd0, 1'b1, 1'b1, 4'd5},   // R5 divide by one
      {3'd4, 8'd1, 8'd0, 1'b0, 1'b1, 4'd8},
      {3'd3, 8'd0, 8'd0, 1'b1, 1'b1, 4'd5},
      {3'd1, 8'd7, 8'd0, 1'b1, 1'b1, 4'd9},
      {3'd3, 8'd0, 8'd0, 1'b1, 1'b0, 4'd9},
      {3'd1, 8'd6, 8'd0, 1'b1, 1'b1, 4'd10},  // R10 stop forces gate
      {3'd3, 8'd0, 8'd0, 1'b1, 1'b1, 4'd6}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         carrier = 1'b0;
   logic         wdt_tap = 1'b0;
   logic         load_en = 1'b0;
   logic [W-1:0] load_val = '0;
   logic         ctl_we = 1'b0;
   logic [2:0]   ctl_val = '0;
   logic         flag_test = 1'b0;
   logic         flag, skip, gate;
   logic [W-1:0] count;
   int           n_run = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtg_burst_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .wdt_tap_i(wdt_tap),
      .load_en_i(load_en), .load_val_i(load_val), .ctl_we_i(ctl_we),
      .ctl_val_i(ctl_val), .flag_test_i(flag_test), .flag_o(flag),
      .skip_o(skip), .count_o(count), .gate_o(gate)
   );

   task automatic check(input int req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse(input bit use_tap, input int high_cyc);
      @(negedge clk);
      if (use_tap) wdt_tap = 1'b1; else carrier = 1'b1;
      repeat (high_cyc) @(negedge clk);
      wdt_tap = 1'b0; carrier = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, "reset count", count, 0);
      check(1, "reset flag", flag, 0);
      check(1, "reset gate", gate, 1);

      for (int i = 0; i < NV; i++) begin
         logic [24:0] v;
         int rq;
         v  = VEC[i];
         rq = int'(v[3:0]);
         case (v[24:22])
            3'd0: begin
               @(negedge clk); load_en = 1'b1; load_val = v[21:14];
               @(negedge clk); load_en = 1'b0;
            end
            3'd1: begin
               @(negedge clk); ctl_we = 1'b1; ctl_val = v[16:14];
               @(negedge clk); ctl_we = 1'b0;
            end
            3'd2: pulse(1'b0, 4);
            3'd3: pulse(1'b1, 4);
            default: begin
               @(negedge clk); flag_test = 1'b1;
               #1 check(rq, "skip", skip, int'(v[14]));
               @(negedge clk); flag_test = 1'b0;
            end
         endcase
         check(rq, $sformatf("row %0d count", i), count, int'(v[13:6]));
         check(rq, $sformatf("row %0d flag", i), flag, int'(v[5]));
         check(rq, $sformatf("row %0d gate", i), gate, int'(v[4]));
      end

      // R4: a long high level counts as one edge
      @(negedge clk); load_en = 1'b1; load_val = 8'd5;
      @(negedge clk); load_en = 1'b0; ctl_we = 1'b1; ctl_val = 3'b001;
      @(negedge clk); ctl_we = 1'b0;
      pulse(1'b0, 20);
      check(4, "long high counted once", count, 4);

      // R1: reset mid-run returns control to stopped
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(1, "re-reset count", count, 0);
      check(1, "re-reset gate", gate, 1);
      pulse(1'b0, 4);
      check(1, "control stopped after reset", flag, 0);
      check(1, "count held after reset", count, 0);

      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end
endmodule